// File: doc/BRIEF.md
# Challenge-Response Enable Gate

This block holds the enable of a protected design low unless a partner device keeps proving that it holds the same secret key. At regular intervals the block sends out a challenge word taken from a 32-bit pseudo-random sequence. It computes locally the token that the challenge should produce under the key. It then waits for the partner to return its own token. A matching token inside the allowed window keeps the design enabled. A wrong token, a late token or a token nobody asked for drops the enable, and the enable stays low until the next reset.

The keyed transform is a small stand-in for a real cipher. It runs a fixed number of rounds over a 32-bit word, and each round mixes in the key with XOR, rotates the word, and adds a round constant.

The sequencer has four states. **GAP** is an idle interval. It leaves for ISSUE when its count reaches GAP-1 and for LOCK on a stray response. **ISSUE** is a single cycle that presents the challenge and captures the expected token. It leaves for WAIT, or for LOCK on a stray response. **WAIT** is the response window. It returns to GAP on a match and goes to LOCK on a mismatch or when the window runs out. **LOCK** is terminal until reset.

Top module: `chal_auth_gate`

## Requirements
- R1: While reset is held and right after it, `design_en` and `chal_valid` are 0. The first challenge appears GAP cycles after reset is released, and it carries the value SEED (default 32'hACE12468).
- R2: Every challenge is a one-cycle pulse on `chal_valid`. Successive challenge words follow a right-shifting Galois LFSR with mask 32'h80200003: the next value is (v >> 1), XORed with the mask when bit 0 of v is 1. The LFSR advances once per challenge and is never zero.
- R3: The expected token for challenge c under `key` (sampled in the challenge cycle) comes from x0 = c and, for rounds r = 0..7, x(r+1) = rotate-left(x(r) XOR key, 7) + (r+1), modulo 2^32. The token is x8.
- R4: A response is accepted when `resp_valid` is sampled at any of the clock edges 1 to TIMEOUT after the challenge cycle's edge. When `resp_data` equals the expected token, `design_en` is 1 from the cycle after that edge.
- R5: After an accepted token, the next challenge is issued GAP cycles later. `design_en` stays 1 through the gap and the following window as long as every round passes.
- R6: A response whose data differs from the expected token drives `design_en` to 0 from the next cycle.
- R7: If no response is sampled by edge TIMEOUT after the challenge, `design_en` is 0 from the cycle after edge TIMEOUT, and it is still 1 in the cycle before that.
- R8: `resp_valid` sampled while no challenge is outstanding (in GAP or ISSUE) counts as a failure and drives `design_en` to 0 from the next cycle.
- R9: After any failure no further challenge is issued, and later responses, even correct ones, leave `design_en` at 0 until reset. Reset restarts the sequence from SEED.
- R10: `design_en` stays 0 from reset until the first accepted token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| key | input | 32 | Secret key, sampled in the challenge cycle |
| chal_valid | output | 1 | One-cycle challenge strobe |
| chal_data | output | 32 | Challenge word, meaningful while chal_valid is 1 |
| resp_valid | input | 1 | Partner response strobe |
| resp_data | input | 32 | Partner token |
| design_en | output | 1 | Enable for the protected design |

## Verification
The challenge strobe appears exactly GAP cycles after reset release or after an accepted edge. The enable changes one cycle after the edge that samples a response, and a timeout takes effect one cycle after edge TIMEOUT. The bench drives every input on the falling edge. It counts falling edges from each reference point and samples each output at the first falling edge after the rising edge that should change it. On timeouts it also checks the falling edge just before that one, so an off-by-one window shows up in both directions. Response delays are swept over every legal value 1..TIMEOUT with several keys, and the challenge words and tokens are predicted by an arithmetic model of R2 and R3.

// File: rtl/auth_pkg.sv
package auth_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_GAP   = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_LOCK  = 2'd3
    } auth_state_e;
endpackage

// File: rtl/auth_lfsr.sv
module auth_lfsr #(
    parameter int          W    = 32,
    parameter logic [31:0] MASK = 32'h80200003,
    parameter logic [31:0] SEED = 32'hACE12468
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED[W-1:0];
        end else if (step) begin
            q <= (q >> 1) ^ (q[0] ? MASK[W-1:0] : '0);
        end
    end

    assign value = q;

    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);
endmodule

// File: rtl/auth_cipher.sv
module auth_cipher
    import auth_pkg::*;
#(
    parameter int ROUNDS = 8,
    parameter int ROT    = 7
) (
    input  word_t key,
    input  word_t din,
    output word_t dout
);
    word_t stage [ROUNDS+1];

    assign stage[0] = din;

    for (genvar r = 0; r < ROUNDS; r++) begin : g_round
        word_t mixed;
        assign mixed        = stage[r] ^ key;
        assign stage[r+1]   = ((mixed << ROT) | (mixed >> (WORD_W - ROT))) + word_t'(r + 1);
    end

    assign dout = stage[ROUNDS];
endmodule

// File: rtl/auth_cycle_cnt.sv
module auth_cycle_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/chal_auth_gate.sv
module chal_auth_gate
    import auth_pkg::*;
#(
    parameter int          GAP     = 64,
    parameter int          TIMEOUT = 32,
    parameter int          ROUNDS  = 8,
    parameter logic [31:0] SEED    = 32'hACE12468
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] key,
    output logic        chal_valid,
    output logic [31:0] chal_data,
    input  logic        resp_valid,
    input  logic [31:0] resp_data,
    output logic        design_en
);
    localparam int CNT_MAX = (GAP > TIMEOUT) ? GAP : TIMEOUT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(TIMEOUT - 1);

    auth_state_e      state_q, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr, cnt_inc;
    logic             lfsr_step;
    word_t            lfsr_val, token_calc, exp_q;
    logic             en_q;
    logic             pass;

    auth_lfsr #(.W(WORD_W), .MASK(32'h80200003), .SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (lfsr_step),
        .value (lfsr_val)
    );

    auth_cipher #(.ROUNDS(ROUNDS), .ROT(7)) u_cipher (
        .key  (key),
        .din  (lfsr_val),
        .dout (token_calc)
    );

    auth_cycle_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    assign pass = (state_q == ST_WAIT) && resp_valid && (resp_data == exp_q);

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_GAP: begin
                if (resp_valid)            state_nx = ST_LOCK;
                else if (cnt == GAP_LAST)  state_nx = ST_ISSUE;
            end
            ST_ISSUE: begin
                state_nx = resp_valid ? ST_LOCK : ST_WAIT;
            end
            ST_WAIT: begin
                if (resp_valid)            state_nx = pass ? ST_GAP : ST_LOCK;
                else if (cnt == WAIT_LAST) state_nx = ST_LOCK;
            end
            ST_LOCK: begin
                state_nx = ST_LOCK;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_GAP;
        else        state_q <= state_nx;
    end

    // per-state outputs
    always_comb begin
        chal_valid = 1'b0;
        lfsr_step  = 1'b0;
        cnt_inc    = 1'b0;
        cnt_clr    = (state_nx != state_q);
        unique case (state_q)
            ST_GAP:   cnt_inc = 1'b1;
            ST_ISSUE: begin
                chal_valid = 1'b1;
                lfsr_step  = 1'b1;
            end
            ST_WAIT:  cnt_inc = 1'b1;
            ST_LOCK:  cnt_inc = 1'b0;
        endcase
    end

    // expected token and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            en_q  <= 1'b0;
        end else begin
            if (state_q == ST_ISSUE) exp_q <= token_calc;
            if (pass)                      en_q <= 1'b1;
            else if (state_nx == ST_LOCK)  en_q <= 1'b0;
        end
    end

    assign chal_data = lfsr_val;
    assign design_en = en_q;

    // R2
    chal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chal_valid |=> !chal_valid);

    // R6
    mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && resp_valid && resp_data != exp_q) |=> !design_en);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK) |=> (state_q == ST_LOCK && !design_en && !chal_valid));

    // R4
    rise_on_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(design_en) |-> $past(resp_valid));

    // R7
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (cnt <= WAIT_LAST));
endmodule

// File: tb/tb_chal_auth_gate.sv
module tb_chal_auth_gate;
    localparam int          CLK_PERIOD = 10;
    localparam int          GAP        = 3;
    localparam int          TIMEOUT    = 5;
    localparam logic [31:0] SEED       = 32'hACE12468;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] key = '0;
    logic        chal_valid;
    logic [31:0] chal_data;
    logic        resp_valid = 1'b0;
    logic [31:0] resp_data = '0;
    logic        design_en;

    int n_total = 0;
    int n_fail  = 0;
    logic [31:0] model_lfsr = SEED;
    logic [31:0] last_tok = '0;

    chal_auth_gate #(.GAP(GAP), .TIMEOUT(TIMEOUT), .ROUNDS(8), .SEED(SEED)) dut (
        .clk(clk), .rst_n(rst_n), .key(key),
        .chal_valid(chal_valid), .chal_data(chal_data),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .design_en(design_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] lfsr_next(input logic [31:0] v);
        return (v >> 1) ^ (v[0] ? 32'h80200003 : 32'h0);
    endfunction

    function automatic logic [31:0] token_of(input logic [31:0] c, input logic [31:0] k);
        logic [31:0] x = c;
        for (int r = 0; r < 8; r++) begin
            logic [31:0] m = x ^ k;
            x = {m[24:0], m[31:25]} + 32'(r + 1);
        end
        return x;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        resp_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(design_en == 1'b0, "R1 reset design_en", 32'(design_en), 32'h0);
        chk(chal_valid == 1'b0, "R1 reset chal_valid", 32'(chal_valid), 32'h0);
        rst_n = 1'b1;
        model_lfsr = SEED;
    endtask

    // counts falling edges until chal_valid is seen; checks gap, word, enable level
    task automatic await_chal(input string req, input bit en_exp, output logic [31:0] c);
        int n = 0;
        bit en_ok = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (!chal_valid && design_en != en_exp) en_ok = 1'b0;
        end while (!chal_valid && n < 50);
        chk(n == GAP, {req, " challenge spacing"}, 32'(n), 32'(GAP));
        chk(en_ok, "R5 enable level through gap", 32'(en_ok), 32'h1);
        chk(chal_data == model_lfsr, "R2 challenge word", chal_data, model_lfsr);
        c = chal_data;
        model_lfsr = lfsr_next(model_lfsr);
    endtask

    // respond after k edges; flip selects a corrupted token
    task automatic do_round(input int k, input logic [31:0] kv, input bit flip,
                            input bit en_before, input bit en_after, input string req);
        logic [31:0] c;
        bit en_ok = 1'b1;
        key = kv;
        await_chal(req, en_before, c);
        last_tok = token_of(c, kv);
        for (int j = 1; j < k; j++) begin
            @(negedge clk);
            if (design_en != en_before) en_ok = 1'b0;
        end
        chk(en_ok, "R5 enable held in window", 32'(en_ok), 32'h1);
        @(negedge clk);
        resp_valid = 1'b1;
        resp_data  = flip ? (last_tok ^ 32'h1) : last_tok;
        @(negedge clk);
        resp_valid = 1'b0;
        chk(design_en == en_after, req, 32'(design_en), 32'(en_after));
    endtask

    task automatic check_locked(input string req);
        bit quiet = 1'b1;
        repeat (GAP + TIMEOUT + 4) begin
            @(negedge clk);
            if (chal_valid || design_en) quiet = 1'b0;
        end
        chk(quiet, req, 32'(quiet), 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_total++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        // R1, R10: reset state and first challenge
        do_reset();
        do_round(1, 32'h0000_0000, 1'b0, 1'b0, 1'b1, "R1 R10 R4 first pass");

        // R3, R4, R5: sweep every response delay with several keys
        for (int kk = 0; kk < 3; kk++) begin
            for (int d = 1; d <= TIMEOUT; d++) begin
                logic [31:0] kv = (kk == 0) ? 32'hFFFF_FFFF :
                                  (kk == 1) ? 32'h1357_9BDF : 32'h8000_0001;
                do_round(d, kv, 1'b0, 1'b1, 1'b1, "R3 R4 token accepted");
            end
        end

        // R6: corrupted token drops enable; R9: stays locked
        do_round(2, 32'h0F0F_F0F0, 1'b1, 1'b1, 1'b0, "R6 mismatch drop");
        check_locked("R9 no challenge after mismatch");
        @(negedge clk);
        resp_valid = 1'b1;
        resp_data  = last_tok;
        @(negedge clk);
        resp_valid = 1'b0;
        chk(design_en == 1'b0, "R9 correct token ignored when locked", 32'(design_en), 32'h0);

        // R9 restart from SEED, then R7 timeout
        do_reset();
        do_round(TIMEOUT, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1, "R9 restart pass");
        begin
            logic [31:0] c;
            key = 32'h2468_ACE0;
            await_chal("R7", 1'b1, c);
            for (int j = 1; j <= TIMEOUT; j++) begin
                @(negedge clk);
                if (j == TIMEOUT)
                    chk(design_en == 1'b1, "R7 still enabled at last window cycle", 32'(design_en), 32'h1);
            end
            @(negedge clk);
            chk(design_en == 1'b0, "R7 timeout drop", 32'(design_en), 32'h0);
        end
        check_locked("R9 no challenge after timeout");

        // R8: stray response during gap
        do_reset();
        do_round(3, 32'h5555_AAAA, 1'b0, 1'b0, 1'b1, "R4 pass before stray");
        @(negedge clk);
        resp_valid = 1'b1;
        resp_data  = last_tok;
        @(negedge clk);
        resp_valid = 1'b0;
        chk(design_en == 1'b0, "R8 stray response drop", 32'(design_en), 32'h0);
        check_locked("R8 R9 locked after stray");

        // R10: a wrong first token never enables
        do_reset();
        do_round(1, 32'h0000_00FF, 1'b1, 1'b0, 1'b0, "R10 wrong first token");
        check_locked("R10 R9 locked before first pass");

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule